// File: doc/BRIEF.md
# APB Requester with Registered Wakeup

This block is the requester end of an APB5 link. A local agent hands it one read or write command at a time over a valid/ready port. The block turns each command into a Setup phase followed by one or more Access phases, and sends back the completer's answer on a response port as a one-cycle pulse.

Before the select line rises, the block raises a wakeup output so that a clock controller further down can ungate the completer's clock. This output comes straight from a flip-flop. A lead-time input sets how many cycles of notice are given. Once a transfer has started, wakeup stays high up to and including the completion cycle. When the agent offers a new command in that completion cycle, the next transfer starts at once and wakeup stays high throughout.

Two request sidebands are driven: a request attribute, and a write-data attribute that is driven only on writes. Both are held for the whole transfer. The read-data attribute and the response attribute are sampled at completion.

Top module: `apb_wake_requester`

## Requirements
- R1: While reset is held, `pwakeup`, `psel`, `penable` and `rsp_valid` are low and `cmd_ready` is high.
- R2: For a command accepted while the block is idle, `pwakeup` rises in the cycle after the acceptance. `psel` rises exactly L cycles later, where L (0 to 7) is the value on `lead_cycles` in the acceptance cycle. With L = 0 both rise in the same cycle. A change of `lead_cycles` at any other time has no effect on the transfer in progress.
- R3: Each transfer has one Setup cycle (`psel`=1, `penable`=0). Access cycles follow (`psel`=1, `penable`=1) until `pready` is sampled high. `cmd_ready` is high only when idle, or in an Access cycle where `pready` is high. `pready` is ignored outside Access cycles.
- R4: Whenever `psel` is high, `pwakeup` is high. It stays high through the cycle in which `pready` completes the transfer.
- R5: If no command is accepted in the completion cycle, `pwakeup` falls in the next cycle. `pwakeup` never falls except right after a completion cycle, and it never rises without a transfer following.
- R6: A command accepted in a completion cycle starts its Setup cycle in the next cycle, with no lead cycles, and `pwakeup` stays high across the boundary.
- R7: `paddr`, `pwrite` and `pauser` carry the accepted command's values from Setup through completion without change.
- R8: On writes, `pwdata` and `pwuser` carry the command's data and write attribute. On reads, both are zero. Both are stable for the whole transfer.
- R9: `rsp_valid` pulses high for one cycle, in the cycle after each completion. `rsp_err` and `rsp_buser` then hold the `pslverr` and `pbuser` values sampled in the completion cycle.
- R10: In a read response, `rsp_rdata` and `rsp_ruser` hold `prdata` and `pruser` from the completion cycle. In a write response, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_cycles | input | LEAD_W | Wakeup lead time, sampled on acceptance from idle |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_auser | input | AUSER_W | Request attribute |
| cmd_wuser | input | DUSER_W | Write-data attribute |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| rsp_err | output | 1 | Completer error |
| rsp_ruser | output | DUSER_W | Read-data attribute (zero for writes) |
| rsp_buser | output | BUSER_W | Response attribute |
| pwakeup | output | 1 | Registered wakeup |
| psel | output | 1 | Select |
| penable | output | 1 | Enable |
| paddr | output | ADDR_W | Address |
| pwrite | output | 1 | Direction |
| pwdata | output | DATA_W | Write data |
| pauser | output | AUSER_W | Request sideband |
| pwuser | output | DUSER_W | Write-data sideband |
| pready | input | 1 | Completer ready |
| prdata | input | DATA_W | Read data |
| pslverr | input | 1 | Completer error |
| pruser | input | DUSER_W | Read-data sideband |
| pbuser | input | BUSER_W | Response sideband |

## Verification
Single writes and single reads, separated by idle gaps, are run at every lead setting from 0 to 7 and with 0 to 2 wait states. This pins down the wakeup-to-select distance, including the case where both rise together, and separates the read and write paths of the sidebands. Bursts of back-to-back commands show whether wakeup stays high across transfer boundaries, and whether a change of lead time in the middle of a burst is correctly left unused. Outside Access cycles the completer model toggles `pready` and drives noise on its returns, which exposes any sampling outside the completion cycle.

// File: rtl/apbw_pkg.sv
package apbw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_SETUP  = 2'd2,
    PH_ACCESS = 2'd3
  } apbw_phase_e;
endpackage

// File: rtl/apbw_seq.sv
module apbw_seq
  import apbw_pkg::*;
#(
  parameter int LEAD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEAD_W-1:0] lead_cycles,
  input  logic              cmd_valid,
  input  logic              pready,
  output logic              cmd_ready,
  output logic              ev_accept,
  output logic              ev_start_idle,
  output logic              ev_complete,
  output logic              ev_last_done,
  output logic              psel,
  output logic              penable
);
  apbw_phase_e       phase_q;
  logic [LEAD_W-1:0] lead_cnt_q;

  function automatic logic lead_last(input logic [LEAD_W-1:0] c);
    return c == LEAD_W'(1);
  endfunction

  function automatic logic lead_none(input logic [LEAD_W-1:0] c);
    return c == '0;
  endfunction

  assign ev_complete   = (phase_q == PH_ACCESS) && pready;
  assign cmd_ready     = (phase_q == PH_IDLE) || ev_complete;
  assign ev_accept     = cmd_valid && cmd_ready;
  assign ev_start_idle = ev_accept && (phase_q == PH_IDLE);
  assign ev_last_done  = ev_complete && !ev_accept;
  assign psel          = (phase_q == PH_SETUP) || (phase_q == PH_ACCESS);
  assign penable       = (phase_q == PH_ACCESS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      lead_cnt_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (ev_accept) begin
            lead_cnt_q <= lead_cycles;
            phase_q    <= lead_none(lead_cycles) ? PH_SETUP : PH_LEAD;
          end
        end
        PH_LEAD: begin
          if (lead_last(lead_cnt_q)) phase_q <= PH_SETUP;
          else lead_cnt_q <= lead_cnt_q - LEAD_W'(1);
        end
        PH_SETUP: phase_q <= PH_ACCESS;
        PH_ACCESS: begin
          if (pready) phase_q <= ev_accept ? PH_SETUP : PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R3: an Access cycle only exists inside a selected transfer
  p_enable_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel);
  // R3: Setup is exactly one cycle and is followed by Access
  p_setup_then_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));
  // R3: Access without ready repeats
  p_access_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !pready) |=> (psel && penable));
endmodule

// File: rtl/apbw_wake.sv
module apbw_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_set,
  input  logic ev_clear,
  input  logic psel,
  input  logic penable,
  input  logic pready,
  output logic pwakeup
);
  logic wake_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        wake_q <= 1'b0;
    else if (ev_set)   wake_q <= 1'b1;
    else if (ev_clear) wake_q <= 1'b0;
  end

  assign pwakeup = wake_q;

  // R4: select never appears without wakeup
  p_sel_under_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> pwakeup);
  // R4: wakeup held until the completing cycle
  p_wake_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwakeup && psel && !(penable && pready)) |=> pwakeup);
  // R5: wakeup only drops right after a completion
  p_wake_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwakeup) |-> $past(psel && penable && pready));
endmodule

// File: rtl/apbw_rsp.sv
module apbw_rsp #(
  parameter int DATA_W  = 32,
  parameter int DUSER_W = 8,
  parameter int BUSER_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_complete,
  input  logic               xfer_write,
  input  logic [DATA_W-1:0]  prdata,
  input  logic               pslverr,
  input  logic [DUSER_W-1:0] pruser,
  input  logic [BUSER_W-1:0] pbuser,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic [DUSER_W-1:0] rsp_ruser,
  output logic [BUSER_W-1:0] rsp_buser
);
  function automatic logic [DATA_W-1:0] read_only_data(input logic wr,
                                                        input logic [DATA_W-1:0] d);
    return wr ? '0 : d;
  endfunction

  function automatic logic [DUSER_W-1:0] read_only_user(input logic wr,
                                                         input logic [DUSER_W-1:0] u);
    return wr ? '0 : u;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      rsp_ruser <= '0;
      rsp_buser <= '0;
    end else begin
      rsp_valid <= ev_complete;
      if (ev_complete) begin
        rsp_rdata <= read_only_data(xfer_write, prdata);
        rsp_ruser <= read_only_user(xfer_write, pruser);
        rsp_err   <= pslverr;
        rsp_buser <= pbuser;
      end
    end
  end

  // R9: completions are at least two cycles apart, so a pulse lasts one cycle
  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/apb_wake_requester.sv
module apb_wake_requester #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int AUSER_W = 8,
  parameter int DUSER_W = 8,
  parameter int BUSER_W = 4,
  parameter int LEAD_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEAD_W-1:0]  lead_cycles,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic [AUSER_W-1:0] cmd_auser,
  input  logic [DUSER_W-1:0] cmd_wuser,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic [DUSER_W-1:0] rsp_ruser,
  output logic [BUSER_W-1:0] rsp_buser,
  output logic               pwakeup,
  output logic               psel,
  output logic               penable,
  output logic [ADDR_W-1:0]  paddr,
  output logic               pwrite,
  output logic [DATA_W-1:0]  pwdata,
  output logic [AUSER_W-1:0] pauser,
  output logic [DUSER_W-1:0] pwuser,
  input  logic               pready,
  input  logic [DATA_W-1:0]  prdata,
  input  logic               pslverr,
  input  logic [DUSER_W-1:0] pruser,
  input  logic [BUSER_W-1:0] pbuser
);
  localparam int REQ_W = ADDR_W + 1 + DATA_W + AUSER_W + DUSER_W;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic               write;
    logic [DATA_W-1:0]  wdata;
    logic [AUSER_W-1:0] auser;
    logic [DUSER_W-1:0] wuser;
  } req_t;

  // named internal events, shared with the assertions
  logic ev_accept, ev_start_idle, ev_complete, ev_last_done;
  req_t req_q, req_d;

  function automatic req_t shape_req(input logic wr, input logic [ADDR_W-1:0] a,
                                     input logic [DATA_W-1:0] d,
                                     input logic [AUSER_W-1:0] au,
                                     input logic [DUSER_W-1:0] wu);
    req_t r;
    r.addr  = a;
    r.write = wr;
    r.auser = au;
    r.wdata = wr ? d  : '0;
    r.wuser = wr ? wu : '0;
    return r;
  endfunction

  apbw_seq #(.LEAD_W(LEAD_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .lead_cycles   (lead_cycles),
    .cmd_valid     (cmd_valid),
    .pready        (pready),
    .cmd_ready     (cmd_ready),
    .ev_accept     (ev_accept),
    .ev_start_idle (ev_start_idle),
    .ev_complete   (ev_complete),
    .ev_last_done  (ev_last_done),
    .psel          (psel),
    .penable       (penable)
  );

  apbw_wake u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_set   (ev_start_idle),
    .ev_clear (ev_last_done),
    .psel     (psel),
    .penable  (penable),
    .pready   (pready),
    .pwakeup  (pwakeup)
  );

  assign req_d = shape_req(cmd_write, cmd_addr, cmd_wdata, cmd_auser, cmd_wuser);

  always_ff @(posedge clk) begin
    if (!rst_n)         req_q <= req_t'({REQ_W{1'b0}});
    else if (ev_accept) req_q <= req_d;
  end

  assign paddr  = req_q.addr;
  assign pwrite = req_q.write;
  assign pwdata = req_q.wdata;
  assign pauser = req_q.auser;
  assign pwuser = req_q.wuser;

  apbw_rsp #(.DATA_W(DATA_W), .DUSER_W(DUSER_W), .BUSER_W(BUSER_W)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_complete (ev_complete),
    .xfer_write  (req_q.write),
    .prdata      (prdata),
    .pslverr     (pslverr),
    .pruser      (pruser),
    .pbuser      (pbuser),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .rsp_ruser   (rsp_ruser),
    .rsp_buser   (rsp_buser)
  );

  // R7: request fields frozen across Access cycles
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> ($stable(paddr) && $stable(pwrite) && $stable(pauser)));
  // R8: write payload frozen, and empty on reads
  p_wpayload_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> ($stable(pwdata) && $stable(pwuser)));
  p_read_no_wpayload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite) |-> (pwuser == '0 && pwdata == '0));
  // R9: a response only follows a completion
  p_rsp_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(psel && penable && pready));
  // R6: back-to-back start keeps wakeup high
  p_b2b_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && cmd_valid) |=> (pwakeup && psel && !penable));
endmodule

// File: tb/test_apb_wake_requester.sv
module test_apb_wake_requester;
  localparam int AW = 16, DW = 32, UAW = 8, UDW = 8, UBW = 4, LW = 3;

  logic clk, rst_n;
  logic [LW-1:0] lead_cycles;
  logic cmd_valid, cmd_ready, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [UAW-1:0] cmd_auser;
  logic [UDW-1:0] cmd_wuser;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [UDW-1:0] rsp_ruser;
  logic [UBW-1:0] rsp_buser;
  logic pwakeup, psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [UAW-1:0] pauser;
  logic [UDW-1:0] pwuser;
  logic pready, pslverr;
  logic [DW-1:0] prdata;
  logic [UDW-1:0] pruser;
  logic [UBW-1:0] pbuser;

  int checks = 0, errors = 0, cycle = 0, b2b_seen = 0;
  bit done_flag = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  apb_wake_requester #(.ADDR_W(AW), .DATA_W(DW), .AUSER_W(UAW), .DUSER_W(UDW),
                       .BUSER_W(UBW), .LEAD_W(LW)) i_apb_wake_requester (
    .clk(clk), .rst_n(rst_n), .lead_cycles(lead_cycles),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_auser(cmd_auser),
    .cmd_wuser(cmd_wuser), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_ruser(rsp_ruser), .rsp_buser(rsp_buser),
    .pwakeup(pwakeup), .psel(psel), .penable(penable), .paddr(paddr),
    .pwrite(pwrite), .pwdata(pwdata), .pauser(pauser), .pwuser(pwuser),
    .pready(pready), .prdata(prdata), .pslverr(pslverr), .pruser(pruser),
    .pbuser(pbuser));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycle, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_wake, m_sel, m_en, m_rspv, rdy, acc, fin;
  int m_wait_lead, m_lead_used;
  logic [AW-1:0] e_addr;  logic e_write;  logic [DW-1:0] e_wdata;
  logic [UAW-1:0] e_auser; logic [UDW-1:0] e_wuser;
  logic [DW-1:0] e_rdata; logic e_err; logic [UDW-1:0] e_ruser; logic [UBW-1:0] e_buser;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wake = 0; m_sel = 0; m_en = 0; m_rspv = 0; m_wait_lead = 0; m_lead_used = 0;
    end else begin
      rdy = !m_wake || (m_en && pready);
      acc = cmd_valid && rdy;
      fin = m_sel && m_en && pready;
      m_rspv = fin;
      if (fin) begin
        e_err = pslverr; e_buser = pbuser;
        e_rdata = e_write ? '0 : prdata;
        e_ruser = e_write ? '0 : pruser;
      end
      if (!m_wake) begin
        if (acc) begin
          m_wake = 1; m_lead_used = int'(lead_cycles);
          if (m_lead_used == 0) m_sel = 1; else m_wait_lead = m_lead_used;
        end
      end else if (!m_sel) begin
        m_wait_lead--;
        if (m_wait_lead == 0) m_sel = 1;
      end else if (!m_en) begin
        m_en = 1;
      end else if (pready) begin
        m_en = 0;
        if (!acc) begin m_sel = 0; m_wake = 0; end
      end
      if (acc) begin
        e_addr = cmd_addr; e_write = cmd_write; e_auser = cmd_auser;
        e_wdata = cmd_write ? cmd_wdata : '0;
        e_wuser = cmd_write ? cmd_wuser : '0;
      end
    end
  end

  // ---------------- checker and completer ----------------
  int wait_cfg = 0, wcnt = 0, t_wake = 0;
  bit prev_wake = 0, prev_sel = 0, prev_en = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cycle++;
      chk(pwakeup === m_wake, "R4 R5 pwakeup", 64'(pwakeup), 64'(m_wake));
      chk(psel === m_sel, "R3 psel", 64'(psel), 64'(m_sel));
      chk(penable === m_en, "R3 penable", 64'(penable), 64'(m_en));
      chk(rsp_valid === m_rspv, "R9 rsp_valid", 64'(rsp_valid), 64'(m_rspv));
      if (m_sel) begin
        chk(paddr === e_addr, "R7 paddr", 64'(paddr), 64'(e_addr));
        chk(pwrite === e_write, "R7 pwrite", 64'(pwrite), 64'(e_write));
        chk(pauser === e_auser, "R7 pauser", 64'(pauser), 64'(e_auser));
        chk(pwdata === e_wdata, "R8 pwdata", 64'(pwdata), 64'(e_wdata));
        chk(pwuser === e_wuser, "R8 pwuser", 64'(pwuser), 64'(e_wuser));
      end
      if (m_rspv) begin
        chk(rsp_err === e_err, "R9 rsp_err", 64'(rsp_err), 64'(e_err));
        chk(rsp_buser === e_buser, "R9 rsp_buser", 64'(rsp_buser), 64'(e_buser));
        chk(rsp_rdata === e_rdata, "R10 rsp_rdata", 64'(rsp_rdata), 64'(e_rdata));
        chk(rsp_ruser === e_ruser, "R10 rsp_ruser", 64'(rsp_ruser), 64'(e_ruser));
      end
      if (pwakeup && !prev_wake) t_wake = cycle;
      if (psel && !prev_sel)
        chk((cycle - t_wake) == m_lead_used, "R2 lead distance",
            64'(cycle - t_wake), 64'(m_lead_used));
      if (prev_sel && prev_en && psel && !penable) begin
        b2b_seen++;
        chk(pwakeup && prev_wake, "R6 wake across boundary", 64'(pwakeup), 64'd1);
      end
      prev_wake = pwakeup; prev_sel = psel; prev_en = penable;
    end
    // completer: answers only matter in Access; noise elsewhere
    if (psel && !penable) wcnt = wait_cfg;
    if (psel && penable) begin
      pready  = (wcnt == 0);
      if (wcnt > 0) wcnt--;
      prdata  = {paddr, ~paddr};
      pruser  = paddr[7:0] ^ 8'h3c;
      pbuser  = paddr[3:0];
      pslverr = paddr[2];
    end else begin
      pready  = cycle[0];
      prdata  = 32'hdead_beef;
      pruser  = 8'hee;
      pbuser  = 4'hf;
      pslverr = 1'b1;
    end
    if (rst_n) begin
      #1;
      chk(cmd_ready === (!m_wake || (m_en && pready)), "R3 cmd_ready",
          64'(cmd_ready), 64'(!m_wake || (m_en && pready)));
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [UAW-1:0] au, input logic [UDW-1:0] wu);
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    cmd_auser = au; cmd_wuser = wu;
    forever begin
      #2;
      if (cmd_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic idle_gap(input int n);
    @(negedge clk);
    cmd_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_addr = '0; cmd_wdata = '0;
    cmd_auser = '0; cmd_wuser = '0; lead_cycles = '0;
    pready = 0; prdata = '0; pslverr = 0; pruser = '0; pbuser = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(!pwakeup && !psel && !penable && !rsp_valid, "R1 outputs idle in reset",
        64'({pwakeup, psel, penable, rsp_valid}), 64'd0);
    chk(cmd_ready === 1'b1, "R1 ready in reset", 64'(cmd_ready), 64'd1);
    @(negedge clk); rst_n = 1;

    for (int l = 0; l < 8; l++) begin
      lead_cycles = LW'(l);
      wait_cfg = l % 3;
      issue(1, AW'(16'h0100 + l * 4), 32'h1111_0000 + l, UAW'(8'ha0 + l), UDW'(8'h50 + l));
      idle_gap(2);
      issue(0, AW'(16'h0200 + l * 4), 32'hffff_ffff, UAW'(8'hb0 + l), UDW'(8'h77));
      idle_gap(4);
    end

    lead_cycles = 3'd2; wait_cfg = 1;
    issue(1, 16'h0304, 32'hcafe_0001, 8'h11, 8'h21);
    lead_cycles = 3'd6;
    issue(0, 16'h0308, 32'h0,         8'h12, 8'h22);
    issue(1, 16'h030c, 32'hcafe_0003, 8'h13, 8'h23);
    issue(0, 16'h0310, 32'h0,         8'h14, 8'h24);
    idle_gap(6);

    lead_cycles = 3'd0; wait_cfg = 0;
    issue(0, 16'h0404, 32'h0,         8'h31, 8'h41);
    issue(1, 16'h0408, 32'hbeef_0002, 8'h32, 8'h42);
    issue(1, 16'h040c, 32'hbeef_0003, 8'h33, 8'h43);
    idle_gap(8);

    chk(b2b_seen >= 5, "R6 back-to-back starts seen", 64'(b2b_seen), 64'd5);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cycle);
    finish_run();
  end
endmodule